// File: doc/BRIEF.md
# Card Command Issue and Response Capture

This block sits between a host register interface and the command side of a memory-card controller. Software writes a 32-bit argument as two 16-bit halves, then writes a 16-bit command word. When the controller is enabled, the block decodes the word, clears its response storage and sends the command index and the argument to the card-side interface as a one-cycle request. The card side later answers with a response of up to 16 bytes and a byte count. A count of zero means nothing came back.

The block sorts the answer by the response type the command word asked for. A response that is too short becomes a timeout. Each response type has its own status error check. A ready check applies to the operating-condition response. The block then packs the response bytes into eight 16-bit words that software can read. It reports the outcome as one-cycle event pulses. A data-transfer command also arms a transfer flag with its direction and asks for the data FIFO to be emptied.

Top module: `cmd_issue_ctrl`

## Requirements
- R1: Write port select `wr_sel` codes are 0 for the command word, 1 for argument bits 15:0 and 2 for argument bits 31:16. A command word carries the index in bits 5:0, the init flag in bit 7, the response type in bits 10:8, the busy flag in bit 11, the command type in bits 13:12 and the data direction in bit 15. An accepted command raises `card_req` for exactly one cycle, in the cycle after the write. During that cycle `card_idx` equals bits 5:0 and `card_arg` equals the assembled argument.
- R2: A command write is ignored when `ctrl_en` is low. It is also ignored while a response is still awaited. An ignored write sends no request, raises no event and leaves the response words and the stored command word unchanged.
- R3: An accepted command sets all eight response words to zero before it is issued.
- R4: A command with index 0 and the init flag set sends no request. It pulses `ev_cmd_done` in the cycle after the write.
- R5: Response types 1, 3 and 6 need at least 4 bytes, and type 2 needs 16. With fewer bytes the block pulses `ev_timeout` without `ev_cmd_done` and the response words stay zero. Types 0, 4, 5 and 7 expect no bytes, end with `ev_cmd_done` and store nothing.
- R6: For type 1, the status is bytes 0..3 read most significant byte first. Status bits 31:26, 24:19 and 16 are errors (mask 0xFDF90000). Bit 3 is also an error when `ake_chk_en` is high. Any error pulses `ev_card_err` together with `ev_cmd_done`.
- R7: For type 6, the status is {byte 2, byte 3}. Bits 15:13 and bit 3 are errors and pulse `ev_card_err` with `ev_cmd_done`.
- R8: For type 3, a clear bit 7 of byte 0 (status bit 31) pulses `ev_not_ready` with `ev_cmd_done`. Types 2 and 3 never raise `ev_card_err`.
- R9: On `card_rsp_bytes`, byte n is bits 8n+7:8n. After a response that is long enough, word k is {byte 2k, byte 2k+1}. Word k is held in register 7-k, which `rd_addr` 7-k selects.
- R10: A command with command type 3 sets `xfer_active`, copies bit 15 to `xfer_dir` and pulses `fifo_flush` in the cycle after the write. Any other issued command clears `xfer_active`.
- R11: `rd_addr` 8 and 9 read the argument low and high halves, and 10 reads the last accepted command word. The argument keeps its value across commands until it is written again.
- R12: Response type 1 with the busy flag set is checked like type 1. It also pulses `ev_busy_wait` with `ev_cmd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_en | input | 1 | Controller enable; command writes need it high |
| ake_chk_en | input | 1 | Adds status bit 3 to the type-1 error check |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 command, 1 argument low, 2 argument high |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read select: 0..7 response words, 8/9 argument, 10 command |
| rd_data | output | 16 | Read data (combinational) |
| card_req | output | 1 | One-cycle command request to the card side |
| card_idx | output | 6 | Command index for the request |
| card_arg | output | 32 | Command argument |
| card_rsp_valid | input | 1 | Card side response strobe |
| card_rsp_len | input | 5 | Number of valid response bytes (0..16) |
| card_rsp_bytes | input | 128 | Response bytes, byte n in bits 8n+7:8n |
| ev_cmd_done | output | 1 | End-of-command pulse |
| ev_timeout | output | 1 | Response timeout pulse |
| ev_card_err | output | 1 | Card status error pulse |
| ev_not_ready | output | 1 | Card-not-ready pulse (type 3) |
| ev_busy_wait | output | 1 | Busy-variant response pulse |
| xfer_active | output | 1 | Data transfer armed |
| xfer_dir | output | 1 | Data transfer direction |
| fifo_flush | output | 1 | Pulse asking the data FIFO to empty |

## Verification
The bench tests responses exactly at their length limits. A 3-byte type-1 answer and a 15-byte type-2 answer must become timeouts, and a design that compares the wrong way would report them done and store stale bytes. It places status bits right beside the error masks: bit 3 with the extra check off and on, bits 12:0 of a type-6 status, and an error-shaped byte under type 3. An error check that is too wide or too narrow then shows up as a wrong `ev_card_err`. It reads every response word after distinct byte patterns, so a swapped byte or a word that is not reversed gives a wrong word. It also writes commands while disabled, while a response is still awaited and with the init shortcut, so a design that issues anyway would raise an extra `card_req` or overwrite the stored command word.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;

  localparam int HALF_W     = 16;
  localparam int ARG_W      = 2 * HALF_W;
  localparam int IDX_W      = 6;
  localparam int RSP_BYTES  = 16;
  localparam int RSP_WORDS  = RSP_BYTES / 2;
  localparam int RSP_BITS   = RSP_BYTES * 8;
  localparam int LEN_W      = $clog2(RSP_BYTES + 1);
  localparam int RD_ADDR_W  = 4;

  localparam logic [1:0] SEL_CMD    = 2'd0;
  localparam logic [1:0] SEL_ARG_LO = 2'd1;
  localparam logic [1:0] SEL_ARG_HI = 2'd2;

  localparam logic [1:0] CTYPE_DATA = 2'd3;

  localparam logic [31:0] R1_ERR_BASE = 32'hFDF9_0000;
  localparam logic [31:0] AUTH_SEQ_BIT = 32'h0000_0008;
  localparam logic [15:0] R6_ERR_MASK = 16'hE008;

  typedef enum logic [2:0] {
    K_NONE,
    K_R1,
    K_R1B,
    K_R2,
    K_R3,
    K_R6
  } rsp_kind_t;

  typedef struct packed {
    logic       dir;
    logic       spare_hi;
    logic [1:0] ctype;
    logic       busy;
    logic [2:0] rtype;
    logic       init;
    logic       spare_lo;
    logic [5:0] idx;
  } cmd_fields_t;

  function automatic rsp_kind_t kind_of(input logic [2:0] rtype, input logic busy);
    case (rtype)
      3'd1:    kind_of = busy ? K_R1B : K_R1;
      3'd2:    kind_of = K_R2;
      3'd3:    kind_of = K_R3;
      3'd6:    kind_of = K_R6;
      default: kind_of = K_NONE;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] need_len(input rsp_kind_t k);
    case (k)
      K_NONE:  need_len = LEN_W'(0);
      K_R2:    need_len = LEN_W'(RSP_BYTES);
      default: need_len = LEN_W'(4);
    endcase
  endfunction

  function automatic logic [31:0] r1_err_mask(input logic ake);
    r1_err_mask = R1_ERR_BASE | (ake ? AUTH_SEQ_BIT : 32'h0);
  endfunction

  function automatic logic [7:0] byte_at(input logic [RSP_BITS-1:0] b, input int n);
    byte_at = b[8*n +: 8];
  endfunction

  function automatic logic [HALF_W-1:0] rsp_word(input logic [RSP_BITS-1:0] b, input int k);
    rsp_word = {byte_at(b, 2*k), byte_at(b, 2*k + 1)};
  endfunction

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import cmdrsp_pkg::*;
(
  input  logic [HALF_W-1:0] cmd_word,
  output logic [IDX_W-1:0]  idx,
  output rsp_kind_t         kind,
  output logic              init_only,
  output logic              is_data,
  output logic              dir
);
  cmd_fields_t f;

  always_comb begin
    f         = cmd_fields_t'(cmd_word);
    idx       = f.idx;
    kind      = kind_of(f.rtype, f.busy);
    init_only = f.init && (f.idx == '0);
    is_data   = (f.ctype == CTYPE_DATA);
    dir       = f.dir;
  end
endmodule

// File: rtl/rsp_classify.sv
module rsp_classify
  import cmdrsp_pkg::*;
(
  input  rsp_kind_t           kind,
  input  logic [LEN_W-1:0]    len,
  input  logic [RSP_BITS-1:0] bytes,
  input  logic                ake_chk_en,
  output logic                timeout,
  output logic                card_err,
  output logic                not_ready,
  output logic                store
);
  logic [31:0] be_status;
  logic [15:0] r6_status;
  logic        short_rsp;

  always_comb begin
    be_status = {byte_at(bytes, 0), byte_at(bytes, 1), byte_at(bytes, 2), byte_at(bytes, 3)};
    r6_status = {byte_at(bytes, 2), byte_at(bytes, 3)};
    short_rsp = (len < need_len(kind));
    timeout   = short_rsp;
    store     = (kind != K_NONE) && !short_rsp;
    card_err  = 1'b0;
    not_ready = 1'b0;
    if (!short_rsp) begin
      case (kind)
        K_R1, K_R1B: card_err  = |(be_status & r1_err_mask(ake_chk_en));
        K_R6:        card_err  = |(r6_status & R6_ERR_MASK);
        K_R3:        not_ready = !be_status[31];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rsp_bank.sv
module rsp_bank
  import cmdrsp_pkg::*;
#(
  parameter int NWORDS = RSP_WORDS,
  localparam int SEL_W = $clog2(NWORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                load,
  input  logic [RSP_BITS-1:0] bytes,
  input  logic [SEL_W-1:0]    rd_sel,
  output logic [HALF_W-1:0]   rd_word,
  output logic                all_zero
);
  logic [HALF_W-1:0] words [NWORDS];

  for (genvar r = 0; r < NWORDS; r++) begin : g_word
    localparam int K = NWORDS - 1 - r;
    logic [HALF_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)     word_q <= '0;
      else if (clr)   word_q <= '0;
      else if (load)  word_q <= rsp_word(bytes, K);
    end
    assign words[r] = word_q;
  end

  always_comb begin
    all_zero = 1'b1;
    for (int i = 0; i < NWORDS; i++) begin
      if (words[i] != '0) all_zero = 1'b0;
    end
  end

  assign rd_word = words[rd_sel];

  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> all_zero);
endmodule

// File: rtl/cmd_issue_ctrl.sv
module cmd_issue_ctrl
  import cmdrsp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctrl_en,
  input  logic                 ake_chk_en,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [HALF_W-1:0]    wr_data,
  input  logic [RD_ADDR_W-1:0] rd_addr,
  output logic [HALF_W-1:0]    rd_data,
  output logic                 card_req,
  output logic [IDX_W-1:0]     card_idx,
  output logic [ARG_W-1:0]     card_arg,
  input  logic                 card_rsp_valid,
  input  logic [LEN_W-1:0]     card_rsp_len,
  input  logic [RSP_BITS-1:0]  card_rsp_bytes,
  output logic                 ev_cmd_done,
  output logic                 ev_timeout,
  output logic                 ev_card_err,
  output logic                 ev_not_ready,
  output logic                 ev_busy_wait,
  output logic                 xfer_active,
  output logic                 xfer_dir,
  output logic                 fifo_flush
);
  localparam int WSEL_W = $clog2(RSP_WORDS);

  logic [ARG_W-1:0]  arg_q;
  logic [HALF_W-1:0] last_cmd_q;
  logic              wait_q;
  rsp_kind_t         kind_q;

  logic [IDX_W-1:0]  dec_idx;
  rsp_kind_t         dec_kind;
  logic              dec_init_only, dec_is_data, dec_dir;

  logic              cmd_wr, accept, rsp_take;
  logic              cl_timeout, cl_err, cl_nready, cl_store;
  logic [HALF_W-1:0] bank_word;
  logic              bank_zero;

  cmd_decode u_dec (
    .cmd_word  (wr_data),
    .idx       (dec_idx),
    .kind      (dec_kind),
    .init_only (dec_init_only),
    .is_data   (dec_is_data),
    .dir       (dec_dir)
  );

  rsp_classify u_cls (
    .kind       (kind_q),
    .len        (card_rsp_len),
    .bytes      (card_rsp_bytes),
    .ake_chk_en (ake_chk_en),
    .timeout    (cl_timeout),
    .card_err   (cl_err),
    .not_ready  (cl_nready),
    .store      (cl_store)
  );

  assign cmd_wr   = wr_en && (wr_sel == SEL_CMD);
  assign accept   = cmd_wr && ctrl_en && !wait_q;
  assign rsp_take = wait_q && card_rsp_valid;

  rsp_bank #(.NWORDS(RSP_WORDS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .load     (rsp_take && cl_store),
    .bytes    (card_rsp_bytes),
    .rd_sel   (rd_addr[WSEL_W-1:0]),
    .rd_word  (bank_word),
    .all_zero (bank_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arg_q        <= '0;
      last_cmd_q   <= '0;
      wait_q       <= 1'b0;
      kind_q       <= K_NONE;
      card_req     <= 1'b0;
      card_idx     <= '0;
      ev_cmd_done  <= 1'b0;
      ev_timeout   <= 1'b0;
      ev_card_err  <= 1'b0;
      ev_not_ready <= 1'b0;
      ev_busy_wait <= 1'b0;
      xfer_active  <= 1'b0;
      xfer_dir     <= 1'b0;
      fifo_flush   <= 1'b0;
    end else begin
      card_req     <= 1'b0;
      ev_cmd_done  <= 1'b0;
      ev_timeout   <= 1'b0;
      ev_card_err  <= 1'b0;
      ev_not_ready <= 1'b0;
      ev_busy_wait <= 1'b0;
      fifo_flush   <= 1'b0;
      if (wr_en && wr_sel == SEL_ARG_LO) arg_q[HALF_W-1:0]     <= wr_data;
      if (wr_en && wr_sel == SEL_ARG_HI) arg_q[ARG_W-1:HALF_W] <= wr_data;
      if (accept) begin
        last_cmd_q <= wr_data;
        kind_q     <= dec_kind;
        if (dec_init_only) begin
          ev_cmd_done <= 1'b1;
        end else begin
          card_req    <= 1'b1;
          card_idx    <= dec_idx;
          wait_q      <= 1'b1;
          xfer_active <= dec_is_data;
          fifo_flush  <= dec_is_data;
          if (dec_is_data) xfer_dir <= dec_dir;
        end
      end else if (rsp_take) begin
        wait_q       <= 1'b0;
        ev_timeout   <= cl_timeout;
        ev_cmd_done  <= !cl_timeout;
        ev_card_err  <= cl_err;
        ev_not_ready <= cl_nready;
        ev_busy_wait <= !cl_timeout && (kind_q == K_R1B);
      end
    end
  end

  assign card_arg = arg_q;

  always_comb begin
    if (rd_addr < RD_ADDR_W'(RSP_WORDS)) rd_data = bank_word;
    else begin
      case (rd_addr)
        RD_ADDR_W'(8):  rd_data = arg_q[HALF_W-1:0];
        RD_ADDR_W'(9):  rd_data = arg_q[ARG_W-1:HALF_W];
        RD_ADDR_W'(10): rd_data = last_cmd_q;
        default:        rd_data = '0;
      endcase
    end
  end

  a_r1_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    card_req |=> !card_req);
  a_r2_disabled_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !ctrl_en) |=> !card_req);
  a_r2_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wait_q && !card_rsp_valid) |=> $stable(last_cmd_q));
  a_r4_init_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec_init_only) |=> (!card_req && ev_cmd_done));
  a_r5_timeout_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_timeout && ev_cmd_done));
  a_r5_timeout_keeps_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |-> bank_zero);
  a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    ev_card_err |-> ev_cmd_done);
  a_r10_flush_arms: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> (xfer_active && card_req));
endmodule

// File: tb/cmd_issue_ctrl_tb_top.sv
module cmd_issue_ctrl_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ctrl_en = 1'b0, ake_chk_en = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd3;
  logic [15:0]  wr_data = '0;
  logic [3:0]   rd_addr = '0;
  logic [15:0]  rd_data;
  logic         card_req;
  logic [5:0]   card_idx;
  logic [31:0]  card_arg;
  logic         card_rsp_valid = 1'b0;
  logic [4:0]   card_rsp_len = '0;
  logic [127:0] card_rsp_bytes = '0;
  logic         ev_cmd_done, ev_timeout, ev_card_err, ev_not_ready, ev_busy_wait;
  logic         xfer_active, xfer_dir, fifo_flush;

  always #10 clk = ~clk;

  cmd_issue_ctrl dut_i (.*);

  int tests = 0, fails = 0;
  int req_count = 0, flush_count = 0;
  logic [5:0]  exp_idx = '0;
  logic [31:0] exp_arg = '0;
  logic [4:0]  mdl_len = '0;
  logic [127:0] mdl_bytes = '0;
  int mdl_cnt = 0;
  logic [4:0] exp_q [$];
  string      tag_q [$];
  bit done_flag = 0;

  // record order: {busy_wait, not_ready, card_err, timeout, done}
  localparam logic [4:0] E_DONE = 5'b00001, E_TO = 5'b00010, E_ERR = 5'b00100,
                         E_NR = 5'b01000, E_BW = 5'b10000;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // card-side model: answers three cycles after a request
  always @(posedge clk) begin
    if (card_req) begin
      mdl_cnt <= 3;
      card_rsp_valid <= 1'b0;
    end else if (mdl_cnt > 1) begin
      mdl_cnt <= mdl_cnt - 1;
      card_rsp_valid <= 1'b0;
    end else if (mdl_cnt == 1) begin
      mdl_cnt <= 0;
      card_rsp_valid <= 1'b1;
      card_rsp_len <= mdl_len;
      card_rsp_bytes <= mdl_bytes;
    end else card_rsp_valid <= 1'b0;
  end

  // monitor: scoreboard for events and request contents
  always @(negedge clk) begin
    if (rst_n) begin
      logic [4:0] ev;
      ev = {ev_busy_wait, ev_not_ready, ev_card_err, ev_timeout, ev_cmd_done};
      if (card_req) begin
        req_count++;
        check(card_idx == exp_idx, "R1 card_idx", card_idx, exp_idx);
        check(card_arg == exp_arg, "R1 card_arg", card_arg, exp_arg);
      end
      if (fifo_flush) flush_count++;
      if (ev != 0) begin
        if (exp_q.size() == 0) check(0, "unexpected event", ev, 0);
        else begin
          logic [4:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(ev == e, t, ev, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [15:0] expv, input string tag);
    @(negedge clk);
    rd_addr = a;
    #2;
    check(rd_data == expv, tag, rd_data, expv);
  endtask

  function automatic logic [127:0] mk(input logic [7:0] b0, b1, b2, b3, input logic [7:0] seed);
    logic [127:0] v;
    for (int n = 0; n < 16; n++) v[8*n +: 8] = seed + 8'(n * 29);
    v[7:0] = b0; v[15:8] = b1; v[23:16] = b2; v[31:24] = b3;
    return v;
  endfunction

  task automatic chk_bank(input logic [127:0] b, input bit stored, input string tag);
    for (int r = 0; r < 8; r++) begin
      int k;
      logic [15:0] e;
      k = 7 - r;
      e = stored ? {b[16*k +: 8], b[16*k + 8 +: 8]} : 16'h0;
      rd_chk(4'(r), e, tag);
    end
  endtask

  task automatic run_cmd(input logic [15:0] cw, input logic [4:0] len, input logic [127:0] b,
                         input logic [4:0] expv, input string tag);
    mdl_len = len; mdl_bytes = b; exp_idx = cw[5:0];
    exp_q.push_back(expv); tag_q.push_back(tag);
    wr(2'd0, cw);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    logic [127:0] b;
    int rc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd_chk(4'd0, 16'h0, "reset rsp word");
    rd_chk(4'd10, 16'h0, "reset last cmd");
    check({card_req, ev_cmd_done, xfer_active} == 0, "reset outputs", {card_req, ev_cmd_done, xfer_active}, 0);

    // R11 argument halves
    wr(2'd1, 16'h1234); wr(2'd2, 16'hABCD);
    exp_arg = 32'hABCD_1234;
    rd_chk(4'd8, 16'h1234, "R11 arg low");
    rd_chk(4'd9, 16'hABCD, "R11 arg high");

    // R2 disabled write ignored
    rc = req_count;
    wr(2'd0, 16'h0111);
    repeat (8) @(negedge clk);
    check(req_count == rc, "R2 no request when disabled", req_count, rc);
    rd_chk(4'd10, 16'h0, "R2 last cmd unchanged");
    ctrl_en = 1'b1;

    // R1/R9 normal type-1, no error
    b = mk(8'h00, 8'h00, 8'h09, 8'h00, 8'h41);
    run_cmd(16'h1111, 5'd16, b, E_DONE, "R1 type1 clean done");
    check(req_count == rc + 1, "R1 one request", req_count, rc + 1);
    chk_bank(b, 1, "R9 word layout");
    rd_chk(4'd10, 16'h1111, "R11 last cmd");
    rd_chk(4'd8, 16'h1234, "R11 arg kept");

    // R6 error bits
    b = mk(8'h80, 8'h00, 8'h00, 8'h00, 8'h07);
    run_cmd(16'h0105, 5'd4, b, E_DONE | E_ERR, "R6 bit31 error");
    b = mk(8'h02, 8'h00, 8'h00, 8'h08, 8'h07);
    run_cmd(16'h0105, 5'd4, b, E_DONE, "R6 bit25 and bit3 not errors");
    ake_chk_en = 1'b1;
    run_cmd(16'h0105, 5'd4, b, E_DONE | E_ERR, "R6 bit3 error with ake");
    ake_chk_en = 1'b0;

    // R12 busy variant
    b = mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h33);
    run_cmd(16'h0907, 5'd4, b, E_DONE | E_BW, "R12 busy variant");

    // R5 short responses
    run_cmd(16'h0107, 5'd3, b, E_TO, "R5 type1 3 bytes timeout");
    chk_bank(b, 0, "R5 words zero after timeout");
    b = mk(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h5A);
    run_cmd(16'h0202, 5'd16, b, E_DONE, "R8 type2 full no error");
    chk_bank(b, 1, "R9 type2 words");
    run_cmd(16'h0202, 5'd15, b, E_TO, "R5 type2 15 bytes timeout");
    chk_bank(b, 0, "R3 words cleared by new command");

    // R8 type 3
    b = mk(8'h7F, 8'hFF, 8'hFF, 8'hFF, 8'h11);
    run_cmd(16'h0329, 5'd4, b, E_DONE | E_NR, "R8 not ready");
    b = mk(8'h80, 8'hFF, 8'hFF, 8'hFF, 8'h11);
    run_cmd(16'h0329, 5'd4, b, E_DONE, "R8 ready no error");

    // R7 type 6
    b = mk(8'hFF, 8'hFF, 8'h20, 8'h00, 8'h22);
    run_cmd(16'h0603, 5'd4, b, E_DONE | E_ERR, "R7 bit13 error");
    b = mk(8'hFF, 8'hFF, 8'h1F, 8'hF7, 8'h22);
    run_cmd(16'h0603, 5'd4, b, E_DONE, "R7 low bits clean");
    b = mk(8'h00, 8'h00, 8'h00, 8'h08, 8'h22);
    run_cmd(16'h0603, 5'd4, b, E_DONE | E_ERR, "R7 bit3 error");

    // R4 init shortcut
    rc = req_count;
    exp_q.push_back(E_DONE); tag_q.push_back("R4 init done");
    wr(2'd0, 16'h0080);
    repeat (8) @(negedge clk);
    check(req_count == rc, "R4 no request", req_count, rc);
    chk_bank(b, 0, "R4 words zero");

    // R5 no-response types store nothing
    run_cmd(16'h0004, 5'd0, b, E_DONE, "R5 type0 done");
    run_cmd(16'h0504, 5'd16, b, E_DONE, "R5 type5 done");
    chk_bank(b, 0, "R5 type5 stores nothing");

    // R10 data transfer
    rc = flush_count;
    b = mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h66);
    run_cmd(16'hB112, 5'd4, b, E_DONE, "R10 data cmd done");
    check(flush_count == rc + 1, "R10 flush pulse", flush_count, rc + 1);
    check(xfer_active && xfer_dir, "R10 armed dir1", {xfer_active, xfer_dir}, 2'b11);
    run_cmd(16'h010D, 5'd4, b, E_DONE, "R10 plain cmd done");
    check(!xfer_active, "R10 cleared", xfer_active, 0);

    // R2 write while awaiting response
    rc = req_count;
    mdl_len = 5'd4; mdl_bytes = b; exp_idx = 6'd13;
    exp_q.push_back(E_DONE); tag_q.push_back("R2 first cmd done");
    wr(2'd0, 16'h010D);
    wr(2'd0, 16'h0116);
    repeat (10) @(negedge clk);
    check(req_count == rc + 1, "R2 second write ignored", req_count, rc + 1);
    rd_chk(4'd10, 16'h010D, "R2 last cmd kept");

    check(exp_q.size() == 0, "all expected events seen", exp_q.size(), 0);
    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      check(0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule